// File: doc/BRIEF.md
# SMBus Alert Responder

This block owns the interrupt side of a small data-acquisition slave on a two-wire bus. When the channel monitor confirms an out-of-limit condition, it raises a one-cycle request together with the offending channel number. The responder latches that channel and pulls its active-low, open-drain alert line. The host then finds the interrupting slave by reading from the shared alert response address. The responder acknowledges that address and shifts out a reply address with the latched channel built into it. Several slaves may answer at once. The responder watches the wired-AND line bit by bit, and it withdraws quietly when a slave with a lower address is talking.

The block does not decode raw SCL/SDA. It consumes one-cycle strobes for START, STOP, SCL rising and SCL falling, plus the sampled SDA level, all produced by a shared front end. Its only bus output is a pull-down enable for SDA. A read addressed to the device's own type also clears the alert. The data returned by that read is not its concern.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `o_alert_n` is 1 and `o_sda_pull` is 0.
- R2: A request pulse on `i_alert_req` drives `o_alert_n` to 0 from the next clock and latches `i_alert_chan`. A request while the alert is already low leaves the latched channel unchanged.
- R3: When the first byte after START is 0x19 (address 0001100, read bit 1) and the alert is low, `o_sda_pull` is 1 from the SCL fall after the eighth bit until the next SCL fall, which is the acknowledge slot.
- R4: The 0x19 byte is not acknowledged while the alert is high, and `o_sda_pull` stays 0 for that whole transfer.
- R5: After the acknowledge, the reply byte goes out MSB first, with each bit presented from an SCL fall. The byte is {TYPE_ID (default 1001), channel[1:0], 1, 1}, and a 0 bit pulls SDA low. Because its last bits are ones, the reply can never be all zeros.
- R6: If SDA samples 0 at an SCL rise while the responder is sending a 1, it releases SDA for the rest of the byte and keeps `o_alert_n` at 0.
- R7: When all eight reply bits are sent without losing arbitration, `o_alert_n` returns to 1 on the clock after the eighth reply SCL rise.
- R8: A first byte whose upper four bits equal TYPE_ID and whose bit 0 is 1 (a read of this device) sets `o_alert_n` to 1 on the clock after its eighth SCL rise. The responder drives nothing in that transfer.
- R9: Any other first byte, including a write (bit 0 = 0) to this device, leaves `o_alert_n` and `o_sda_pull` unchanged.
- R10: A START strobe restarts address reception from the first bit, whatever point the current transfer has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | One-cycle START / repeated START strobe |
| i_stop | input | 1 | One-cycle STOP strobe |
| i_scl_rise | input | 1 | One-cycle SCL rising-edge strobe |
| i_scl_fall | input | 1 | One-cycle SCL falling-edge strobe |
| i_sda | input | 1 | Sampled SDA line level |
| i_alert_req | input | 1 | Confirmed-alert request pulse from the monitor |
| i_alert_chan | input | CHAN_W | Channel that caused the alert |
| o_sda_pull | output | 1 | SDA pull-down enable (1 = drive low) |
| o_alert_n | output | 1 | Alert pin level, active low |

## Verification
A wrong bit count or phase shows up at once: the acknowledge or a reply bit arrives one SCL slot early or late, and the per-slot SDA pull comparison catches it within the same byte. A wrongly kept or wrongly cleared pending flag shows on `o_alert_n` one clock after the SCL rise that should or should not have cleared it. A channel latch that follows a second request is seen in the channel bits of the next reply. A stuck or missing arbitration-lost flag appears as SDA pulled low in a slot after a lost bit, or as the alert released after a lost byte.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    localparam int BYTE_W = 8;
    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACKW,
        PH_ACKD,
        PH_SEND,
        PH_PARK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_ara_read(input logic [BYTE_W-1:0] b);
        return b == {ARA_ADDR, 1'b1};
    endfunction

endpackage

// File: rtl/sar_alert_latch.sv
module sar_alert_latch #(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_req,
    input  logic [CHAN_W-1:0] i_chan,
    input  logic              i_clr,
    output logic              o_pending,
    output logic [CHAN_W-1:0] o_chan
);

    logic              pend_q;
    logic [CHAN_W-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            chan_q <= '0;
        end else if (i_req && (!pend_q || i_clr)) begin
            pend_q <= 1'b1;
            chan_q <= i_chan;
        end else if (i_clr) begin
            pend_q <= 1'b0;
        end
    end

    assign o_pending = pend_q;
    assign o_chan    = chan_q;

endmodule

// File: rtl/sar_bus_seq.sv
module sar_bus_seq
    import smb_alert_pkg::*;
#(
    parameter int              TYPE_W  = 4,
    parameter logic [TYPE_W-1:0] TYPE_ID = 4'b1001
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t i_ev,
    input  logic    i_pending,
    output phase_e  o_phase,
    output logic    o_read_hit,
    output logic    o_ack_drive,
    output logic    o_sending,
    output logic    o_load,
    output logic    o_shift,
    output logic    o_sample,
    output logic    o_last
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] byte_now;
    logic              at_last;

    assign byte_now = {rx_q[BYTE_W-2:0], i_ev.sda};
    assign at_last  = (cnt_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
        end else if (i_ev.start) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
        end else if (i_ev.stop) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_ADDR: begin
                    if (i_ev.rise) begin
                        rx_q  <= byte_now;
                        cnt_q <= cnt_q + 1'b1;
                        if (at_last) begin
                            phase_q <= (is_ara_read(byte_now) && i_pending) ? PH_ACKW : PH_PARK;
                        end
                    end
                end
                PH_ACKW: if (i_ev.fall) phase_q <= PH_ACKD;
                PH_ACKD: begin
                    if (i_ev.fall) begin
                        phase_q <= PH_SEND;
                        cnt_q   <= '0;
                    end
                end
                PH_SEND: begin
                    if (i_ev.rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (at_last) phase_q <= PH_PARK;
                    end
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

    assign o_phase     = phase_q;
    assign o_read_hit  = (phase_q == PH_ADDR) && i_ev.rise && at_last && !i_ev.start && !i_ev.stop
                         && (byte_now[BYTE_W-1 -: TYPE_W] == TYPE_ID) && byte_now[0];
    assign o_ack_drive = (phase_q == PH_ACKD);
    assign o_sending   = (phase_q == PH_SEND);
    assign o_load      = (phase_q == PH_ACKD) && i_ev.fall && !i_ev.start && !i_ev.stop;
    assign o_shift     = (phase_q == PH_SEND) && i_ev.fall;
    assign o_sample    = (phase_q == PH_SEND) && i_ev.rise;
    assign o_last      = o_sample && at_last && !i_ev.start && !i_ev.stop;

endmodule

// File: rtl/sar_arb_tx.sv
module sar_arb_tx
    import smb_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_load,
    input  logic [BYTE_W-1:0] i_data,
    input  logic              i_shift,
    input  logic              i_sample,
    input  logic              i_sda,
    input  logic              i_active,
    output logic              o_drive,
    output logic              o_lost,
    output logic              o_clash
);

    logic [BYTE_W-1:0] sh_q;
    logic              lost_q;

    assign o_clash = i_sample && !lost_q && sh_q[BYTE_W-1] && !i_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            lost_q <= 1'b0;
        end else if (i_load) begin
            sh_q   <= i_data;
            lost_q <= 1'b0;
        end else begin
            if (i_shift) sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
            if (o_clash) lost_q <= 1'b1;
        end
    end

    assign o_drive = i_active && !lost_q && !sh_q[BYTE_W-1];
    assign o_lost  = lost_q;

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
    import smb_alert_pkg::*;
#(
    parameter int                CHAN_W  = 2,
    parameter int                TYPE_W  = 4,
    parameter logic [TYPE_W-1:0] TYPE_ID = 4'b1001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_start,
    input  logic              i_stop,
    input  logic              i_scl_rise,
    input  logic              i_scl_fall,
    input  logic              i_sda,
    input  logic              i_alert_req,
    input  logic [CHAN_W-1:0] i_alert_chan,
    output logic              o_sda_pull,
    output logic              o_alert_n
);

    localparam int PAD_W = BYTE_W - TYPE_W - CHAN_W;

    bus_ev_t           ev;
    phase_e            phase;
    logic              pending;
    logic [CHAN_W-1:0] chan_q;
    logic              read_hit, ack_drive, sending;
    logic              load, shift, sample, last;
    logic              tx_drive, tx_lost, tx_clash;
    logic              clr;
    logic [BYTE_W-1:0] reply;

    assign ev = '{start: i_start, stop: i_stop, rise: i_scl_rise, fall: i_scl_fall, sda: i_sda};

    generate
        if (PAD_W > 0) begin : g_pad
            assign reply = {TYPE_ID, chan_q, {PAD_W{1'b1}}};
        end else begin : g_nopad
            assign reply = BYTE_W'({TYPE_ID, chan_q});
        end
    endgenerate

    sar_bus_seq #(.TYPE_W(TYPE_W), .TYPE_ID(TYPE_ID)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .i_ev       (ev),
        .i_pending  (pending),
        .o_phase    (phase),
        .o_read_hit (read_hit),
        .o_ack_drive(ack_drive),
        .o_sending  (sending),
        .o_load     (load),
        .o_shift    (shift),
        .o_sample   (sample),
        .o_last     (last)
    );

    sar_arb_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .i_load  (load),
        .i_data  (reply),
        .i_shift (shift),
        .i_sample(sample),
        .i_sda   (i_sda),
        .i_active(sending),
        .o_drive (tx_drive),
        .o_lost  (tx_lost),
        .o_clash (tx_clash)
    );

    assign clr = read_hit || (last && !tx_lost && !tx_clash);

    sar_alert_latch #(.CHAN_W(CHAN_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .i_req    (i_alert_req),
        .i_chan   (i_alert_chan),
        .i_clr    (clr),
        .o_pending(pending),
        .o_chan   (chan_q)
    );

    assign o_sda_pull = ack_drive || tx_drive;
    assign o_alert_n  = !pending;

endmodule

// File: rtl/smb_alert_responder_sva.sv
module smb_alert_responder_sva
    import smb_alert_pkg::*;
#(
    parameter int CHAN_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              i_alert_req,
    input logic              i_scl_rise,
    input logic              o_sda_pull,
    input logic              o_alert_n,
    input phase_e            phase,
    input logic [CHAN_W-1:0] chan_q
);

    // R4: the line is only ever pulled while an alert is pending
    p_pull_only_pending_r4: assert property (@(posedge clk) disable iff (rst)
        o_sda_pull |-> !o_alert_n);

    // R2: the alert pin falls only after a request
    p_assert_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(o_alert_n) |-> $past(i_alert_req));

    // R7 and R8: release happens only on an SCL rise
    p_release_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(o_alert_n) |-> $past(i_scl_rise));

    // R9: nothing is driven while the address byte is being received
    p_quiet_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |-> !o_sda_pull);

    // R2: the latched channel holds while the alert stays low
    p_chan_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!o_alert_n && $past(!o_alert_n) && !$past(i_scl_rise)) |-> $stable(chan_q));

endmodule

bind smb_alert_responder smb_alert_responder_sva #(.CHAN_W(CHAN_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .i_alert_req(i_alert_req),
    .i_scl_rise (i_scl_rise),
    .o_sda_pull (o_sda_pull),
    .o_alert_n  (o_alert_n),
    .phase      (phase),
    .chan_q     (chan_q)
);

// File: tb/smb_alert_responder_tb.sv
module smb_alert_responder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i_start = 0, i_stop = 0, i_scl_rise = 0, i_scl_fall = 0;
    logic       i_alert_req = 0;
    logic [1:0] i_alert_chan = 0;
    logic       m_sda = 1'b1, r_sda = 1'b1;
    logic       o_sda_pull, o_alert_n;
    logic       line;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic       exp_pend = 0;
    logic [1:0] exp_chan = 0;

    logic [1:0] q_val[$];
    int         q_req[$];

    always #5 clk = ~clk;

    assign line = m_sda & r_sda & ~o_sda_pull;

    smb_alert_responder u_dut (
        .clk(clk), .rst(rst), .i_start(i_start), .i_stop(i_stop),
        .i_scl_rise(i_scl_rise), .i_scl_fall(i_scl_fall), .i_sda(line),
        .i_alert_req(i_alert_req), .i_alert_chan(i_alert_chan),
        .o_sda_pull(o_sda_pull), .o_alert_n(o_alert_n)
    );

    task automatic chk(input logic ok, input int req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // monitor: compares {pull, alert_n} against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (q_val.size() != 0) begin
                logic [1:0] e;
                int r;
                e = q_val.pop_front();
                r = q_req.pop_front();
                chk({o_sda_pull, o_alert_n} == e, r, "pull/alert_n", {o_sda_pull, o_alert_n}, e);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) i_start = 1;
        @(negedge clk) i_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) begin i_stop = 1; m_sda = 1; r_sda = 1; end
        @(negedge clk) i_stop = 0;
    endtask

    // one SCL period; expectation pushed in the SCL-high window
    task automatic bit_slot(input logic mbit, input logic obit, input logic exp_pull, input int req);
        @(negedge clk) begin m_sda = mbit; r_sda = obit; end
        @(negedge clk);
        @(negedge clk) i_scl_rise = 1;
        @(negedge clk) i_scl_rise = 0;
        @(negedge clk) begin q_val.push_back({exp_pull, ~exp_pend}); q_req.push_back(req); end
        @(negedge clk);
        @(negedge clk) i_scl_fall = 1;
        @(negedge clk) i_scl_fall = 0;
    endtask

    task automatic raise(input logic [1:0] ch);
        @(negedge clk) begin i_alert_req = 1; i_alert_chan = ch; end
        @(negedge clk) i_alert_req = 0;
        if (!exp_pend) begin exp_pend = 1; exp_chan = ch; end
        // R2: alert low one clock after the request
        chk(o_alert_n == 1'b0, 2, "alert after request", {1'b0, o_alert_n}, 2'b00);
    endtask

    task automatic txn(input logic [7:0] addr, input logic rival_on, input logic [7:0] rival);
        logic acked, lost, mine, other, ep;
        logic [7:0] own;
        int rq;
        pulse_start();
        for (int i = 0; i < 8; i++) begin
            // R8: read of own type clears at the eighth rise; R9 otherwise
            if (i == 7 && addr[7:4] == 4'b1001 && addr[0]) exp_pend = 0;
            bit_slot(addr[7-i], 1'b1, 1'b0, (addr[7:4] == 4'b1001) ? 8 : 9);
        end
        acked = (addr == 8'h19) && exp_pend;
        bit_slot(1'b1, 1'b1, acked, acked ? 3 : 4);   // R3 / R4 acknowledge slot
        if (acked) begin
            own  = {4'b1001, exp_chan, 2'b11};        // R5 reply layout
            lost = 0;
            for (int i = 0; i < 8; i++) begin
                mine  = own[7-i];
                other = rival_on ? rival[7-i] : 1'b1;
                ep    = !lost && !mine;
                if (!lost && mine && !other) lost = 1;   // R6
                if (i == 7 && !lost) exp_pend = 0;       // R7
                rq = lost ? 6 : ((i == 7) ? 7 : 5);
                bit_slot(1'b1, other, ep, rq);
            end
            bit_slot(1'b1, 1'b1, 1'b0, 5);            // master NACK
        end
        pulse_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(o_alert_n == 1'b1, 1, "alert_n after reset", {1'b0, o_alert_n}, 2'b01);
        chk(o_sda_pull == 1'b0, 1, "pull after reset", {1'b0, o_sda_pull}, 2'b00);

        txn(8'h19, 0, 8'hFF);          // R4: no alert, no acknowledge
        raise(2'd2);                   // R2
        raise(2'd1);                   // R2: channel must stay 2
        txn(8'h90, 0, 8'hFF);          // R9: write to own address ignored
        txn(8'hA5, 0, 8'hFF);          // R9: foreign address ignored
        txn(8'h19, 1, 8'h93);          // R6: lower rival wins at bit 4
        txn(8'h19, 0, 8'hFF);          // R5, R7: solo win, reply 0x9B
        raise(2'd0);
        txn(8'h19, 1, 8'hBF);          // R6, R7: higher rival loses, reply 0x93
        raise(2'd3);
        txn(8'h91, 0, 8'hFF);          // R8: direct read clears
        txn(8'h19, 0, 8'hFF);          // R4 after clear
        raise(2'd1);
        pulse_start();                 // R10: abandoned address, then restart
        for (int i = 0; i < 4; i++) bit_slot(i[0], 1'b1, 1'b0, 10);
        txn(8'h19, 0, 8'hFF);          // R10, R5, R7: reply 0x97

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule